// File: doc/BRIEF.md
# Compare-Mode Timer Channel

This block is one up-counting timer channel with a small register interface. A counter, `CNT_W` bits wide, advances on count enables taken from one of several sources: four power-of-two divisions of the system clock, a slow tick pulse supplied from outside, or an external clock pin that is sampled in the system clock domain. Two compare registers, A and C, are checked against the counter on every count. A compare on C can restart the count at zero, giving a periodic event, or halt the channel, giving a one-shot.

Each compare can set, clear or toggle the waveform pin `tioa`, so software can make a square wave or a pulse without touching the pin. Compare and wrap events set sticky status flags. A status read clears them. A mask decides which flags drive `irq`. A command write enables or disables counting or restarts the count, and `sync_trg` restarts it from the surrounding block.

Top module: `tmr_chan`

## Requirements
- R1: With mode bits 3 and 4 both clear (free-running), each count adds one and wraps from the all-ones value to 0. A match on C does not reset the count. The wrap sets status bit 0.
- R2: With mode bit 3 set (restart on C) and bit 4 clear, a count taken while the counter equals C loads 0. After a restart, N counts leave the value N mod (C+1).
- R3: With mode bit 4 set (halt on C), a count taken while the counter equals C leaves the counter at C and turns the channel off. Status bit 3 then reads 0.
- R4: A write to address 0 is a command: bit 0 turns counting on, bit 1 turns it off and bit 2 restarts. A restart sets the counter to 0 and does not turn counting on. While counting is off, the counter holds its value. Status bit 3 shows whether counting is on.
- R5: If one command write sets both bit 0 and bit 1, counting ends up off.
- R6: A one-cycle pulse on `sync_trg` sets the counter to 0, in the same way as command bit 2.
- R7: Status (address 5) holds the flags in bits [2:0]: bit 0 is wrap, bit 1 is A compare and bit 2 is C compare. A read with `rd_en` clears them, but an event in the same cycle still sets its flag. Writing address 6 sets mask bits and writing address 7 clears them, so 0xFF clears the whole mask. Reading address 6 returns the mask. `irq` is high while any flag has its mask bit set.
- R8: Mode bits [6:5] give the pin action on an A compare and bits [8:7] the action on a C compare: 0 none, 1 set, 2 clear, 3 toggle. When both compares hit on the same count, only the C action applies. A compare counts as a hit when a count is taken while the counter equals the register. Status bit 4 reads `tioa`.
- R9: Mode bits [2:0] select the count source. Codes 0 to 3 divide the system clock by 2^(BASE_LOG2+STEP_LOG2·k). Code 4 counts `slow_tick` pulses. Code 5 counts rising edges of `ext_in`, seen through a two-flop synchronizer. Codes 6 and 7 never count.
- R10: Addresses 1, 2, 3 and 4 read back the mode, A, C and the counter value. A write to address 1, 2 or 3 loads the mode, A or C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (status read clears flags) |
| addr | input | 3 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` |
| slow_tick | input | 1 | Slow count-enable pulse (source 4) |
| ext_in | input | 1 | External clock input (source 5) |
| sync_trg | input | 1 | Block-level restart pulse |
| tioa | output | 1 | Waveform output |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with an 8-bit counter, BASE_LOG2=1 and STEP_LOG2=1. The divided sources are then 2, 4, 8 and 16 cycles, so all four can be measured exactly over a 64-cycle window. A full wrap takes only 256 counts, so the bench can step through it count by count with `slow_tick`. This makes it possible to sweep every restart length against mod (C+1), to follow a complete square-wave period cycle by cycle, and to see the halt and mask behaviour.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int NFLAG  = 3;
   localparam int MODE_W = 9;

   localparam logic [2:0] A_CMD  = 3'd0;
   localparam logic [2:0] A_MODE = 3'd1;
   localparam logic [2:0] A_RA   = 3'd2;
   localparam logic [2:0] A_RC   = 3'd3;
   localparam logic [2:0] A_CV   = 3'd4;
   localparam logic [2:0] A_STAT = 3'd5;
   localparam logic [2:0] A_IEN  = 3'd6;
   localparam logic [2:0] A_IDIS = 3'd7;

   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_SET  = 2'd1,
      ACT_CLR  = 2'd2,
      ACT_TGL  = 2'd3
   } act_e;
endpackage

// File: rtl/tmr_tick.sv
module tmr_tick #(
   parameter int BASE_LOG2 = 1,
   parameter int STEP_LOG2 = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] sel,
   input  logic       slow_tick,
   input  logic       ext_in,
   output logic       tick
);
   localparam int NDIV  = 4;
   localparam int PRE_W = BASE_LOG2 + STEP_LOG2 * (NDIV - 1);

   if (BASE_LOG2 < 1) begin : g_bad_base
      $error("tmr_tick: BASE_LOG2 must be at least 1");
   end
   if (STEP_LOG2 < 1) begin : g_bad_step
      $error("tmr_tick: STEP_LOG2 must be at least 1");
   end

   logic [PRE_W-1:0] pre_q;
   logic [NDIV-1:0]  div_tick;
   logic [2:0]       ext_q;
   logic             ext_tick;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q <= '0;
         ext_q <= '0;
      end else begin
         pre_q <= pre_q + 1'b1;
         ext_q <= {ext_q[1:0], ext_in};
      end
   end

   for (genvar k = 0; k < NDIV; k++) begin : g_div
      localparam int LW = BASE_LOG2 + STEP_LOG2 * k;
      assign div_tick[k] = &pre_q[LW-1:0];
   end

   assign ext_tick = ext_q[1] & ~ext_q[2];

   always_comb begin
      case (sel)
         3'd0, 3'd1, 3'd2, 3'd3: tick = div_tick[sel[1:0]];
         3'd4:                   tick = slow_tick;
         3'd5:                   tick = ext_tick;
         default:                tick = 1'b0;
      endcase
   end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             trig,
   input  logic             en_cmd,
   input  logic             dis_cmd,
   input  logic             auto_rst,
   input  logic             stop_rc,
   input  logic [CNT_W-1:0] ra,
   input  logic [CNT_W-1:0] rc,
   output logic [CNT_W-1:0] cnt,
   output logic             clk_on,
   output logic             ev_ovf,
   output logic             ev_ra,
   output logic             ev_rc
);
   logic step;

   assign step   = tick & clk_on & ~trig;
   assign ev_ra  = step & (cnt == ra);
   assign ev_rc  = step & (cnt == rc);
   assign ev_ovf = step & (&cnt) & ~(ev_rc & (auto_rst | stop_rc));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         clk_on <= 1'b0;
      end else begin
         if (trig)
            cnt <= '0;
         else if (step) begin
            if (ev_rc && stop_rc)
               cnt <= cnt;
            else if (ev_rc && auto_rst)
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end

         if (dis_cmd)
            clk_on <= 1'b0;
         else if (en_cmd)
            clk_on <= 1'b1;
         else if (ev_rc && stop_rc)
            clk_on <= 1'b0;
      end
   end
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave
   import tmr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ev_ra,
   input  logic ev_rc,
   input  act_e ra_act,
   input  act_e rc_act,
   output logic wave
);
   function automatic logic apply_act(input act_e a, input logic cur);
      case (a)
         ACT_SET: return 1'b1;
         ACT_CLR: return 1'b0;
         ACT_TGL: return ~cur;
         default: return cur;
      endcase
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n)
         wave <= 1'b0;
      else if (ev_rc)
         wave <= apply_act(rc_act, wave);
      else if (ev_ra)
         wave <= apply_act(ra_act, wave);
   end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int DATA_W    = 16,
   parameter int BASE_LOG2 = 1,
   parameter int STEP_LOG2 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [2:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              slow_tick,
   input  logic              ext_in,
   input  logic              sync_trg,
   output logic              tioa,
   output logic              irq
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("tmr_chan: CNT_W must be at least 2");
   end
   if (DATA_W < CNT_W || DATA_W < MODE_W || DATA_W < 8) begin : g_bad_data
      $error("tmr_chan: DATA_W too narrow for counter, mode or mask");
   end

   logic [MODE_W-1:0] mode_q;
   logic [CNT_W-1:0]  ra_q, rc_q, cnt;
   logic [NFLAG-1:0]  imr_q, flag_q, ev_vec;
   logic              wr_cmd, en_cmd, dis_cmd, trig, rd_stat;
   logic              tick, clk_on, ev_ovf, ev_ra, ev_rc;
   logic [2:0]        sel;
   logic              auto_rst, stop_rc;
   act_e              ra_act, rc_act;

   assign sel      = mode_q[2:0];
   assign auto_rst = mode_q[3];
   assign stop_rc  = mode_q[4];
   assign ra_act   = act_e'(mode_q[6:5]);
   assign rc_act   = act_e'(mode_q[8:7]);

   assign wr_cmd  = wr_en && (addr == A_CMD);
   assign en_cmd  = wr_cmd & wdata[0];
   assign dis_cmd = wr_cmd & wdata[1];
   assign trig    = (wr_cmd & wdata[2]) | sync_trg;
   assign rd_stat = rd_en && (addr == A_STAT);
   assign ev_vec  = {ev_rc, ev_ra, ev_ovf};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         ra_q   <= '0;
         rc_q   <= '0;
         imr_q  <= '0;
         flag_q <= '0;
      end else begin
         if (wr_en) begin
            case (addr)
               A_MODE:  mode_q <= wdata[MODE_W-1:0];
               A_RA:    ra_q   <= wdata[CNT_W-1:0];
               A_RC:    rc_q   <= wdata[CNT_W-1:0];
               A_IEN:   imr_q  <= imr_q | wdata[NFLAG-1:0];
               A_IDIS:  imr_q  <= imr_q & ~wdata[NFLAG-1:0];
               default: ;
            endcase
         end
         flag_q <= (rd_stat ? '0 : flag_q) | ev_vec;
      end
   end

   tmr_tick #(.BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2)) tick_i (
      .clk(clk), .rst_n(rst_n), .sel(sel), .slow_tick(slow_tick),
      .ext_in(ext_in), .tick(tick)
   );

   tmr_count #(.CNT_W(CNT_W)) count_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .trig(trig),
      .en_cmd(en_cmd), .dis_cmd(dis_cmd), .auto_rst(auto_rst),
      .stop_rc(stop_rc), .ra(ra_q), .rc(rc_q), .cnt(cnt),
      .clk_on(clk_on), .ev_ovf(ev_ovf), .ev_ra(ev_ra), .ev_rc(ev_rc)
   );

   tmr_wave wave_i (
      .clk(clk), .rst_n(rst_n), .ev_ra(ev_ra), .ev_rc(ev_rc),
      .ra_act(ra_act), .rc_act(rc_act), .wave(tioa)
   );

   assign irq = |(flag_q & imr_q);

   always_comb begin
      rdata = '0;
      case (addr)
         A_MODE: rdata = DATA_W'(mode_q);
         A_RA:   rdata = DATA_W'(ra_q);
         A_RC:   rdata = DATA_W'(rc_q);
         A_CV:   rdata = DATA_W'(cnt);
         A_STAT: rdata = DATA_W'({tioa, clk_on, flag_q});
         A_IEN:  rdata = DATA_W'(imr_q);
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             trig,
   input logic             clk_on,
   input logic             en_cmd,
   input logic             dis_cmd,
   input logic             auto_rst,
   input logic             stop_rc,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] rc,
   input logic [2:0]       imr,
   input logic             wr_en,
   input logic [2:0]       addr,
   input logic [7:0]       wlow
);
   AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && clk_on && !trig && !auto_rst && !stop_rc)
      |=> cnt == CNT_W'($past(cnt) + 1'b1));                          // R1
   AST_AUTO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && clk_on && !trig && auto_rst && !stop_rc && cnt == rc)
      |=> cnt == '0);                                                  // R2
   AST_STOP_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && clk_on && !trig && stop_rc && cnt == rc && !en_cmd)
      |=> (!clk_on && $stable(cnt)));                                  // R3
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_on && !trig) |=> $stable(cnt));                            // R4
   AST_TRIG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> cnt == '0);                                             // R6
   AST_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      dis_cmd |=> !clk_on);                                            // R5
   AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 3'd7 && wlow == 8'hFF) |=> imr == '0);         // R7
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .tick(tick), .trig(trig), .clk_on(clk_on),
   .en_cmd(en_cmd), .dis_cmd(dis_cmd), .auto_rst(auto_rst),
   .stop_rc(stop_rc), .cnt(cnt), .rc(rc_q), .imr(imr_q),
   .wr_en(wr_en), .addr(addr), .wlow(wdata[7:0])
);

// File: tb/tmr_chan_tb.sv
module tmr_chan_tb_top;
   localparam int CW = 8;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0]    addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          slow_tick = 1'b0, ext_in = 1'b0, sync_trg = 1'b0;
   logic          tioa, irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tmr_chan #(.CNT_W(CW), .DATA_W(DW), .BASE_LOG2(1), .STEP_LOG2(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .slow_tick(slow_tick), .ext_in(ext_in),
      .sync_trg(sync_trg), .tioa(tioa), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input int d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = DW'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output int v);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 v = int'(rdata);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); slow_tick = 1'b1;
         @(negedge clk); slow_tick = 1'b0;
      end
   endtask

   function automatic int mk_mode(int sel, int au, int st, int aa, int ca);
      return sel | (au << 3) | (st << 4) | (aa << 5) | (ca << 7);
   endfunction

   function automatic logic act_apply(int a, logic cur);
      case (a)
         1: return 1'b1;
         2: return 1'b0;
         3: return ~cur;
         default: return cur;
      endcase
   endfunction

   initial begin
      repeat (2000000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int v, a, b, ra, rc, aa, ca;
      logic t;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rd(3'd4, v); chk("R10 reset cv", v, 0);
      rd(3'd5, v); chk("R7 reset status", v, 0);
      chk("R7 reset irq", int'(irq), 0);
      chk("R8 reset tioa", int'(tioa), 0);

      // R10 register readback
      wr(3'd1, mk_mode(4, 0, 0, 0, 0)); rd(3'd1, v); chk("R10 mode", v, 4);
      wr(3'd2, 8'h5A); rd(3'd2, v); chk("R10 ra", v, 8'h5A);
      wr(3'd3, 10); rd(3'd3, v); chk("R10 rc", v, 10);

      // R4 disabled: no counting; trigger does not enable
      ticks(3); rd(3'd4, v); chk("R4 idle hold", v, 0);
      wr(3'd0, 4); rd(3'd5, v); chk("R4 trig no enable", (v >> 3) & 1, 0);

      // R1 free-run wrap, ignores RC
      rd(3'd5, v);
      wr(3'd0, 5);
      ticks(255); rd(3'd4, v); chk("R1 passes rc to max", v, 255);
      rd(3'd5, v); chk("R1 no wrap yet", v & 1, 0);
      ticks(1); rd(3'd4, v); chk("R1 wrap to zero", v, 0);
      rd(3'd5, v); chk("R1 wrap flag", v & 1, 1);
      rd(3'd5, v); chk("R7 clear on read", v & 7, 0);

      // R5 disable wins
      wr(3'd0, 3); rd(3'd5, v); chk("R5 disable wins", (v >> 3) & 1, 0);
      rd(3'd4, a); ticks(4); rd(3'd4, b); chk("R4 hold when off", b, a);

      // R6 sync trigger
      wr(3'd0, 1); ticks(7);
      @(negedge clk); sync_trg = 1'b1; @(negedge clk); sync_trg = 1'b0;
      rd(3'd4, v); chk("R6 sync_trg zero", v, 0);

      // R2 restart sweep
      for (int r = 1; r <= 6; r += 5) begin
         wr(3'd1, mk_mode(4, 1, 0, 0, 0)); wr(3'd3, r);
         for (int n = 0; n <= 14; n++) begin
            wr(3'd0, 5); ticks(n); rd(3'd4, v);
            chk("R2 period", v, n % (r + 1));
         end
      end

      // R3 halt on C
      wr(3'd1, mk_mode(4, 0, 1, 0, 0)); wr(3'd3, 7);
      wr(3'd0, 5); ticks(20); rd(3'd4, v); chk("R3 halts at rc", v, 7);
      rd(3'd5, v); chk("R3 clock off", (v >> 3) & 1, 0);
      chk("R3 rc flag", (v >> 2) & 1, 1);
      ticks(3); rd(3'd4, v); chk("R3 stays", v, 7);

      // R7 interrupt mask
      wr(3'd1, mk_mode(4, 1, 0, 0, 0)); wr(3'd3, 3);
      rd(3'd5, v);
      wr(3'd6, 4); rd(3'd6, v); chk("R7 mask read", v, 4);
      wr(3'd0, 5); ticks(3); chk("R7 irq before", int'(irq), 0);
      ticks(1); chk("R7 irq on rc", int'(irq), 1);
      rd(3'd5, v); chk("R7 rc flag", (v >> 2) & 1, 1);
      chk("R7 irq cleared", int'(irq), 0);
      wr(3'd7, 8'hFF); rd(3'd6, v); chk("R7 mask cleared", v, 0);
      ticks(4); chk("R7 masked irq", int'(irq), 0);
      rd(3'd5, v); chk("R7 flag still set", (v >> 2) & 1, 1);

      // R8 waveform: set/clear, toggle with RC priority, square wave
      for (int p = 0; p < 3; p++) begin
         if (p == 0) begin ra = 2; rc = 5; aa = 1; ca = 2; end
         else if (p == 1) begin ra = 3; rc = 3; aa = 3; ca = 3; end
         else begin ra = 0; rc = 128; aa = 1; ca = 2; end
         wr(3'd1, mk_mode(4, (p == 2) ? 0 : 1, 0, aa, ca));
         wr(3'd2, ra); wr(3'd3, rc);
         wr(3'd0, 5);
         #1 t = tioa;
         v = 0;
         for (int i = 0; i < ((p == 2) ? 256 : 20); i++) begin
            if (v == rc) t = act_apply(ca, t);
            else if (v == ra) t = act_apply(aa, t);
            if (p != 2 && v == rc) v = 0; else v = (v + 1) % 256;
            ticks(1);
            chk("R8 tioa", int'(tioa), int'(t));
         end
      end

      // R9 divided sources
      for (int k = 0; k < 4; k++) begin
         wr(3'd1, mk_mode(k, 0, 0, 0, 0)); wr(3'd0, 5);
         @(negedge clk); addr = 3'd4;
         #1 a = int'(rdata);
         repeat (64) @(negedge clk);
         #1 b = int'(rdata);
         chk("R9 divider", (b - a) & 255, 64 >> (k + 1));
      end

      // R9 external edges, slow_tick ignored
      wr(3'd1, mk_mode(5, 0, 0, 0, 0)); wr(3'd0, 5);
      ticks(3);
      for (int e = 0; e < 5; e++) begin
         @(negedge clk); ext_in = 1'b1; repeat (4) @(negedge clk);
         ext_in = 1'b0; repeat (4) @(negedge clk);
      end
      rd(3'd4, v); chk("R9 ext edges", v, 5);

      // R9 unused code never counts
      wr(3'd1, mk_mode(6, 0, 0, 0, 0)); wr(3'd0, 5);
      ticks(4); repeat (40) @(negedge clk);
      rd(3'd4, v); chk("R9 code 6 idle", v, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule